// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Controller

A parameterized general-purpose I/O controller on a simple single-cycle register bus. A bus write is one cycle with `bus_sel` and `bus_wr` high. A read is combinational: `bus_rdata` shows the addressed register while `bus_sel` is high and `bus_wr` is low, and is zero at all other times. The controller keeps an output-value register and a direction register. It drives the output-enable and output-value vectors of tri-state pads, and it samples the pad levels back through a two-flop synchronizer.

Three build-time choices select the variant:

- `OUT_MODE` sets how the output value is written:
  - 0: the data register is written directly.
  - 1: the data register is written directly, and atomic set and clear registers are added.
  - 2: the output value is written only at the set address, and the data register is used for input only.
- `DIR_MODE` sets the direction register:
  - 0: no direction register.
  - 1: the register marks outputs.
  - 2: the register marks inputs.
- `REVERSE` flips the mapping between pins and register bits.

Register offsets on `bus_addr` are fixed: data = 0, set = 1, clear = 2, direction = 3. A unit of `bus_addr` selects one whole register. The line count equals the register width `W`, which must be 8, 16, 32 or 64.

Top module: `gpio_ctrl`

## Requirements
- R1: During reset and after it, `pad_out` and `pad_oe` are all zero. The direction register (offset 3) reads all zeros when `DIR_MODE`=1 and all ones when `DIR_MODE`=2.
- R2: When `OUT_MODE` is 0 or 1, a write to the data register (offset 0) replaces the output value. A read of offset 0 returns the driven output value for every line that is an output.
- R3: When `OUT_MODE`=1, writing offset 1 (set) forces high each line whose written bit is 1. Lines whose written bit is 0 keep their value.
- R4: When `OUT_MODE`=1, writing offset 2 (clear) forces low each line whose written bit is 1. Lines whose written bit is 0 keep their value.
- R5: Reads of offset 1 and offset 2 return zero in every mode.
- R6: When `OUT_MODE`=2, a write to offset 1 replaces the whole output value, and a write to offset 0 has no effect on `pad_out`.
- R7: When `DIR_MODE`=1, a 1 in the direction register enables the line's output driver and a 0 makes the line an input. Without a bus write, `pad_out` and `pad_oe` hold their values.
- R8: When `DIR_MODE`=2, a 1 in the direction register makes the line an input and a 0 enables its output driver.
- R9: When `DIR_MODE`=0, `pad_oe` equals the output value bit by bit, so a line drives only while its value is 1. Offset 3 reads zero.
- R10: When `REVERSE`=1, pin n corresponds to register bit W-1-n. This applies to `pad_out`, `pad_oe` and the input bits returned by a read of offset 0.
- R11: For an input line, a read of offset 0 shows a new pad level only after the second rising clock edge following the change. After the first edge it still shows the old level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data, zero when no read is in progress |
| pad_in | input | W | Pad levels, indexed by pin |
| pad_oe | output | W | Pad output enables, indexed by pin |
| pad_out | output | W | Pad output values, indexed by pin |

## Verification
The hardest situation to produce from the ports is the synchronizer window. In that window a pad change must stay invisible to a data read after one edge and appear after the next. The bench changes `pad_in` on a falling edge and reads on each of the following two falling edges. A second hard situation combines a reversed, input-marking variant with a split output register. In it, a line is both driven and sampled, and the read-back must take its value from the driver and not from the pad. A dedicated instance reaches this by first writing the output register and the direction register, and then presenting pad levels that disagree with the driven value.

// File: rtl/gpio_pkg.sv
// Shared definitions for the GPIO controller: register offsets and the
// encodings of the build-time output and direction modes.
package gpio_pkg;
    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_SET  = 2'd1,
        REG_CLR  = 2'd2,
        REG_DIR  = 2'd3
    } gpio_reg_e;

    localparam int OUTM_DIRECT = 0;  // data register written directly
    localparam int OUTM_SETCLR = 1;  // data register plus set/clear strobes
    localparam int OUTM_SPLIT  = 2;  // output register at set offset

    localparam int DIRM_NONE    = 0; // no direction register
    localparam int DIRM_OUTMARK = 1; // 1 = output
    localparam int DIRM_INMARK  = 2; // 1 = input
endpackage

// File: rtl/gpio_in_sync.sv
// Two-stage synchronizer for the pad input levels.
// Assumes each bit is an independent asynchronous level; no bus coherence
// across bits is implied. Reset clears both stages.
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Shift the pad levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_bit_map.sv
// Maps between pin order and register bit order. With REVERSE set, element n
// goes to position W-1-n; otherwise it passes straight through. Reversal is
// its own inverse, so the same block serves both directions.
module gpio_bit_map #(
    parameter int W       = 8,
    parameter bit REVERSE = 1'b0
) (
    input  logic [W-1:0] vec_in,
    output logic [W-1:0] vec_out
);
    if (REVERSE) begin : g_rev
        for (genvar n = 0; n < W; n++) begin : g_bit
            assign vec_out[n] = vec_in[W-1-n];
        end
    end else begin : g_fwd
        assign vec_out = vec_in;
    end
endmodule

// File: rtl/gpio_regs.sv
// Output-value and direction registers of the GPIO controller, in register
// bit order. Applies the write side effects of the chosen output mode and
// derives per-bit output enables from the chosen direction polarity.
// Assumes one bus write at most per cycle.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W        = 8,
    parameter int OUT_MODE = OUTM_SETCLR,
    parameter int DIR_MODE = DIRM_OUTMARK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] out_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] oe
);
    localparam logic [W-1:0] DIR_RST = (DIR_MODE == DIRM_INMARK) ? '1 : '0;

    logic         hit_data, hit_set, hit_clr, hit_dir;
    logic         load_en;
    logic [W-1:0] set_mask, clr_mask, out_next;

    // Decode which register a write targets.
    always_comb begin
        hit_data = wr_en && (addr == REG_DATA);
        hit_set  = wr_en && (addr == REG_SET);
        hit_clr  = wr_en && (addr == REG_CLR);
        hit_dir  = wr_en && (addr == REG_DIR);
    end

    // Select the write side effect for the output register per mode.
    always_comb begin
        load_en  = 1'b0;
        set_mask = '0;
        clr_mask = '0;
        if (OUT_MODE == OUTM_SPLIT) begin
            load_en = hit_set;
        end else begin
            load_en = hit_data;
            if (OUT_MODE == OUTM_SETCLR) begin
                set_mask = hit_set ? wdata : '0;
                clr_mask = hit_clr ? wdata : '0;
            end
        end
        // Clear wins over set for any bit both would touch.
        out_next = load_en ? wdata : ((out_q | set_mask) & ~clr_mask);
    end

    // Hold the output value.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_next;
    end

    if (DIR_MODE == DIRM_NONE) begin : g_nodir
        assign dir_q = '0;
        assign oe    = out_q;
    end else begin : g_dir
        logic [W-1:0] dir_r;

        // Hold the direction register; reset selects input on every line.
        always_ff @(posedge clk) begin
            if (!rst_n)       dir_r <= DIR_RST;
            else if (hit_dir) dir_r <= wdata;
        end

        assign dir_q = dir_r;
        if (DIR_MODE == DIRM_OUTMARK) begin : g_out
            assign oe = dir_r;
        end else begin : g_in
            assign oe = ~dir_r;
        end
    end
endmodule

// File: rtl/gpio_ctrl.sv
// Top of the memory-mapped GPIO controller. Decodes the single-cycle register
// bus, maps register bits to pins, synchronizes the pad inputs and muxes the
// read-back. Reads are combinational and return zero outside a read access.
// Assumes W is 8, 16, 32 or 64.
module gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int W        = 8,
    parameter int OUT_MODE = OUTM_SETCLR,
    parameter int DIR_MODE = DIRM_OUTMARK,
    parameter bit REVERSE  = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_sel,
    input  logic         bus_wr,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out
);
    if (W != 8 && W != 16 && W != 32 && W != 64) begin : g_bad_w
        $error("gpio_ctrl: W must be 8, 16, 32 or 64");
    end

    logic         wr_en;
    logic [W-1:0] out_q, dir_q, oe_reg;
    logic [W-1:0] in_sync_pin, in_reg, data_view;

    assign wr_en = bus_sel && bus_wr;

    gpio_regs #(.W(W), .OUT_MODE(OUT_MODE), .DIR_MODE(DIR_MODE)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .out_q (out_q),
        .dir_q (dir_q),
        .oe    (oe_reg)
    );

    gpio_in_sync #(.W(W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (in_sync_pin)
    );

    gpio_bit_map #(.W(W), .REVERSE(REVERSE)) u_map_in (
        .vec_in  (in_sync_pin),
        .vec_out (in_reg)
    );

    gpio_bit_map #(.W(W), .REVERSE(REVERSE)) u_map_out (
        .vec_in  (out_q),
        .vec_out (pad_out)
    );

    gpio_bit_map #(.W(W), .REVERSE(REVERSE)) u_map_oe (
        .vec_in  (oe_reg),
        .vec_out (pad_oe)
    );

    // Driven lines report their output value, the others their pad level.
    assign data_view = (out_q & oe_reg) | (in_reg & ~oe_reg);

    // Read-back multiplexer; set and clear offsets are write-only.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                REG_DATA: bus_rdata = data_view;
                REG_DIR:  bus_rdata = dir_q;
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_ctrl_chk.sv
// Property checker for gpio_ctrl, attached by bind. Observes the bus and pad
// ports only and computes the pin mapping on its own.
module gpio_ctrl_chk
    import gpio_pkg::*;
#(
    parameter int W        = 8,
    parameter int OUT_MODE = OUTM_SETCLR,
    parameter bit REVERSE  = 1'b0
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_sel,
    input logic         bus_wr,
    input logic [1:0]   bus_addr,
    input logic [W-1:0] bus_wdata,
    input logic [W-1:0] bus_rdata,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] pad_out
);
    function automatic logic [W-1:0] to_pins(input logic [W-1:0] v);
        logic [W-1:0] r;
        for (int n = 0; n < W; n++) r[n] = REVERSE ? v[W-1-n] : v[n];
        return r;
    endfunction

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && pad_out == '0));

    // R2
    data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (OUT_MODE != OUTM_SPLIT && bus_sel && bus_wr && bus_addr == REG_DATA)
        |=> pad_out == to_pins($past(bus_wdata)));

    // R3
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (OUT_MODE == OUTM_SETCLR && bus_sel && bus_wr && bus_addr == REG_SET)
        |=> (pad_out & to_pins($past(bus_wdata))) == to_pins($past(bus_wdata)));

    // R4
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (OUT_MODE == OUTM_SETCLR && bus_sel && bus_wr && bus_addr == REG_CLR)
        |=> (pad_out & to_pins($past(bus_wdata))) == '0);

    // R5
    wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (bus_addr == REG_SET || bus_addr == REG_CLR))
        |-> bus_rdata == '0);

    // R6
    split_data_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (OUT_MODE == OUTM_SPLIT && bus_sel && bus_wr && bus_addr == REG_DATA)
        |=> $stable(pad_out));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.W(W), .OUT_MODE(OUT_MODE), .REVERSE(REVERSE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out)
);

// File: tb/gpio_ctrl_tb_top.sv
// Bench for gpio_ctrl: a vector table for the set/clear, output-marking
// variant, then directed tests on that and two other variants.
module gpio_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        sel_main = 0, sel_alt = 0, sel_nd = 0;
    logic        bus_wr = 0;
    logic [1:0]  bus_addr = 0;
    logic [15:0] bus_wdata = 0;
    logic [7:0]  rd_main, oe_main, po_main, pin_main = 0;
    logic [15:0] rd_alt, oe_alt, po_alt, pin_alt = 0;
    logic [7:0]  rd_nd, oe_nd, po_nd, pin_nd = 0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Main variant: 8 bits, set/clear, direction marks outputs, normal order.
    gpio_ctrl #(.W(8), .OUT_MODE(1), .DIR_MODE(1), .REVERSE(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel_main), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata[7:0]), .bus_rdata(rd_main),
        .pad_in(pin_main), .pad_oe(oe_main), .pad_out(po_main));

    // Alternate: 16 bits, split output register, direction marks inputs, reversed.
    gpio_ctrl #(.W(16), .OUT_MODE(2), .DIR_MODE(2), .REVERSE(1'b1)) dut_alt_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel_alt), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_alt),
        .pad_in(pin_alt), .pad_oe(oe_alt), .pad_out(po_alt));

    // No direction register, direct data writes.
    gpio_ctrl #(.W(8), .OUT_MODE(0), .DIR_MODE(0), .REVERSE(1'b0)) dut_nd_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel_nd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata[7:0]), .bus_rdata(rd_nd),
        .pad_in(pin_nd), .pad_oe(oe_nd), .pad_out(po_nd));

    typedef struct packed {
        logic [1:0] addr;
        logic [7:0] wdata;
        logic [7:0] exp_out;
        logic [7:0] exp_oe;
        logic [7:0] req;
    } vec_t;

    // Offsets: 0 data, 1 set, 2 clear, 3 direction.
    localparam vec_t VECS [10] = '{
        '{2'd3, 8'h0F, 8'h00, 8'h0F, 8'd7},   // R7 low nibble outputs
        '{2'd0, 8'hA5, 8'hA5, 8'h0F, 8'd2},   // R2 direct load
        '{2'd1, 8'h0A, 8'hAF, 8'h0F, 8'd3},   // R3 set some bits
        '{2'd2, 8'h81, 8'h2E, 8'h0F, 8'd4},   // R4 clear some bits
        '{2'd1, 8'h00, 8'h2E, 8'h0F, 8'd3},   // R3 zero mask no change
        '{2'd2, 8'hFF, 8'h00, 8'h0F, 8'd4},   // R4 clear all
        '{2'd3, 8'hF0, 8'h00, 8'hF0, 8'd7},   // R7 swap direction
        '{2'd0, 8'h3C, 8'h3C, 8'hF0, 8'd2},   // R2 reload
        '{2'd2, 8'h0C, 8'h30, 8'hF0, 8'd4},   // R4
        '{2'd1, 8'hC1, 8'hF1, 8'hF0, 8'd3}    // R3
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input int which, input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        sel_main = (which == 0); sel_alt = (which == 1); sel_nd = (which == 2);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        sel_main = 0; sel_alt = 0; sel_nd = 0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int which, input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        sel_main = (which == 0); sel_alt = (which == 1); sel_nd = (which == 2);
        bus_wr = 1'b0; bus_addr = a;
        #1;
        v = (which == 0) ? {8'h00, rd_main} : (which == 1) ? rd_alt : {8'h00, rd_nd};
        sel_main = 0; sel_alt = 0; sel_nd = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state on all variants
        check("R1 main oe", {8'h0, oe_main}, 16'h0);
        check("R1 main out", {8'h0, po_main}, 16'h0);
        bus_read(0, 2'd3, v); check("R1 main dir", v, 16'h0000);
        bus_read(1, 2'd3, v); check("R1 R8 alt dir", v, 16'hFFFF);
        check("R1 alt oe", oe_alt, 16'h0);
        check("R1 nd oe", {8'h0, oe_nd}, 16'h0);

        // Vector walk on the main variant
        for (int i = 0; i < 10; i++) begin
            bus_write(0, VECS[i].addr, {8'h00, VECS[i].wdata});
            check($sformatf("R%0d vec%0d out", VECS[i].req, i), {8'h0, po_main}, {8'h0, VECS[i].exp_out});
            check($sformatf("R%0d vec%0d oe", VECS[i].req, i), {8'h0, oe_main}, {8'h0, VECS[i].exp_oe});
        end

        // R2 R11 read-back mixes driven value and synchronized inputs
        @(negedge clk); pin_main = 8'h5A;
        repeat (2) @(negedge clk);
        bus_read(0, 2'd0, v); check("R2 data mix", v, 16'h00FA);

        // R5 write-only offsets read zero; R7 direction reads back
        bus_read(0, 2'd1, v); check("R5 set reads zero", v, 16'h0);
        bus_read(0, 2'd2, v); check("R5 clr reads zero", v, 16'h0);
        bus_read(0, 2'd3, v); check("R7 dir readback", v, 16'h00F0);

        // R11 two-edge synchronizer latency
        @(negedge clk); pin_main = 8'h00;
        repeat (3) @(negedge clk);
        pin_main = 8'h0F;
        bus_read(0, 2'd0, v); check("R11 after one edge", v, 16'h00F0);
        bus_read(0, 2'd0, v); check("R11 after two edges", v, 16'h00FF);

        // R6 R10 split output register, reversed order
        bus_write(1, 2'd1, 16'h0001);
        check("R6 R10 alt out", po_alt, 16'h8000);
        check("R8 alt oe all inputs", oe_alt, 16'h0000);
        bus_write(1, 2'd3, 16'hFFFE);
        check("R8 R10 alt oe", oe_alt, 16'h8000);
        bus_write(1, 2'd0, 16'h1234);
        check("R6 data write ignored", po_alt, 16'h8000);
        @(negedge clk); pin_alt = 16'h0001;
        repeat (2) @(negedge clk);
        bus_read(1, 2'd0, v); check("R10 alt read", v, 16'h8001);
        bus_read(1, 2'd1, v); check("R5 alt set reads zero", v, 16'h0);

        // R9 no direction register
        bus_write(2, 2'd0, 16'h0096);
        check("R9 nd out", {8'h0, po_nd}, 16'h0096);
        check("R9 nd oe", {8'h0, oe_nd}, 16'h0096);
        bus_read(2, 2'd3, v); check("R9 nd dir zero", v, 16'h0);

        // R1 reset in mid-run clears state again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 re-reset out", {8'h0, po_main}, 16'h0);
        check("R1 re-reset alt oe", oe_alt, 16'h0);

        finish_run();
    end
endmodule